// File: doc/BRIEF.md
# Dual-Channel Buck Fault Supervisor

This block watches the digitised protection comparators of a two-channel step-down controller. For each channel it decides whether the high-side and low-side gate drivers may switch, and whether the internal output discharge switch is closed. The PWM logic that times each driver pulse sits elsewhere. It only switches a driver that this block permits.

Faults come in two kinds. Latched faults hold until the channel's own enable is driven low or the block is reset. These are feedback over-voltage, filtered feedback under-voltage, absolute output over-voltage, and a shutdown caused by the peer channel. Self-clearing faults follow their input: supply lock-out and over-temperature. Different faults leave the drivers in different states.

An over-voltage clamps the output through the low-side switch. An under-voltage turns both drivers off and discharges the output. Under-voltage is blanked for a window after enable while the soft start runs. It must then persist for a filter window before it latches. Under-voltage and absolute over-voltage on one channel also shut the other channel down.

Top module: `vfs_top`

## Requirements
- R1: While a channel's enable is low, its high-side and low-side permits are 0 and its discharge output is 1.
- R2: Over-voltage sampled at a clock edge while enabled latches the channel as high-side 0, low-side 1, discharge 0 from that edge. The latch holds after the flag drops.
- R3: Once blanking has ended, under-voltage held for UV_FILT consecutive edges latches the channel as high-side 0, low-side 0, discharge 1, starting at the UV_FILT-th edge.
- R4: An under-voltage run shorter than UV_FILT edges latches nothing. Each new run restarts the count from zero.
- R5: For the first UV_BLANK edges after enable rises, under-voltage is ignored and does not count.
- R6: Absolute output over-voltage latches its own channel as high-side 0, low-side 1, discharge 0 at the sampling edge.
- R7: When one channel holds an under-voltage or absolute over-voltage latch, the other channel latches high-side 0, low-side 0, discharge 1 one edge later. That shutdown holds until the other channel's own enable goes low.
- R8: While supply lock-out or over-temperature is 1, every enabled channel without an over-voltage latch has both permits 0 and discharge 1. It returns to running (both permits 1, discharge 0) in the same cycle the flags clear, with nothing latched.
- R9: An edge with the channel's enable low clears all of that channel's latches. After re-enable and with no faults, it runs again.
- R10: An over-voltage latch sets the driver state ahead of under-voltage, peer shutdown, lock-out and over-temperature.
- R11: A discharging channel never has either driver permit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_en | input | NCH | Per-channel enable |
| fb_ov | input | NCH | Feedback above over-voltage threshold |
| fb_uv | input | NCH | Feedback below under-voltage threshold |
| out_abs_ov | input | NCH | Output above absolute over-voltage limit |
| sup_lockout | input | 1 | Supply below lock-out threshold |
| over_temp | input | 1 | Die over-temperature (hysteresis applied upstream) |
| hs_permit | output | NCH | High-side driver may switch |
| ls_permit | output | NCH | Low-side driver may switch / is held on |
| dis_on | output | NCH | Output discharge switch closed |

## Verification
The assertions assume the comparator flags are already synchronous to the clock and settled one cycle before the edge that samples them. They also assume supply lock-out and over-temperature arrive with their hysteresis already applied. The stimulus changes every input just after a rising edge and holds it for whole cycles. Per-channel sweeps run each fault on each channel in turn, with small filter and blanking windows, so that each boundary count is reached exactly.

// File: rtl/vfs_pkg.sv
package vfs_pkg;

    typedef enum logic [1:0] {
        DM_RUN   = 2'd0,
        DM_CLAMP = 2'd1,
        DM_OFF   = 2'd2
    } drv_mode_e;

    typedef struct packed {
        logic hs;
        logic ls;
        logic dis;
    } drv_t;

    typedef struct packed {
        logic ov;
        logic uv;
        logic abs;
        logic peer;
    } latch_t;

    function automatic drv_t mode_drive(drv_mode_e m);
        drv_t d;
        case (m)
            DM_RUN:   d = '{hs: 1'b1, ls: 1'b1, dis: 1'b0};
            DM_CLAMP: d = '{hs: 1'b0, ls: 1'b1, dis: 1'b0};
            default:  d = '{hs: 1'b0, ls: 1'b0, dis: 1'b1};
        endcase
        return d;
    endfunction

    function automatic drv_mode_e pick_mode(logic en, latch_t l, logic glob_off);
        drv_mode_e m;
        if (!en)                   m = DM_OFF;
        else if (l.ov)             m = DM_CLAMP;
        else if (l.uv || l.peer)   m = DM_OFF;
        else if (glob_off)         m = DM_OFF;
        else if (l.abs)            m = DM_CLAMP;
        else                       m = DM_RUN;
        return m;
    endfunction

endpackage

// File: rtl/vfs_uv_filter.sv
module vfs_uv_filter #(
    parameter int UV_FILT  = 32,
    parameter int UV_BLANK = 2000
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic uv,
    output logic fire
);
    localparam int FW = $clog2(UV_FILT + 1);
    localparam int BW = $clog2(UV_BLANK + 1);

    logic [BW-1:0] blank_cnt;
    logic [FW-1:0] filt_cnt;
    logic          armed;
    logic          qual;

    assign armed = (blank_cnt == BW'(UV_BLANK));
    assign qual  = en && armed && uv;
    assign fire  = qual && (filt_cnt == FW'(UV_FILT - 1));

    always_ff @(posedge clk) begin
        if (rst || !en)
            blank_cnt <= '0;
        else if (!armed)
            blank_cnt <= blank_cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || !qual || fire)
            filt_cnt <= '0;
        else
            filt_cnt <= filt_cnt + 1'b1;
    end

    p_uv_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
        filt_cnt <= FW'(UV_FILT - 1));

    p_blank_no_count_r5: assert property (@(posedge clk) disable iff (rst)
        !armed |=> filt_cnt == '0);

endmodule

// File: rtl/vfs_ch_latch.sv
module vfs_ch_latch
    import vfs_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  logic      ov,
    input  logic      uv_fire,
    input  logic      abs_ov,
    input  logic      peer_trip,
    input  logic      glob_off,
    output drv_mode_e mode,
    output logic      trip
);
    latch_t lat;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            lat <= '0;
        end else begin
            if (ov)        lat.ov   <= 1'b1;
            if (uv_fire)   lat.uv   <= 1'b1;
            if (abs_ov)    lat.abs  <= 1'b1;
            if (peer_trip) lat.peer <= 1'b1;
        end
    end

    assign mode = pick_mode(en, lat, glob_off);
    assign trip = lat.uv || lat.abs;

    p_latch_clear_r9: assert property (@(posedge clk) disable iff (rst)
        !en |=> lat == '0);

    p_ov_holds_r2: assert property (@(posedge clk) disable iff (rst)
        (lat.ov && en) ##1 en |-> lat.ov);

endmodule

// File: rtl/vfs_top.sv
module vfs_top
    import vfs_pkg::*;
#(
    parameter int NCH      = 2,
    parameter int UV_FILT  = 32,
    parameter int UV_BLANK = 2000
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] ch_en,
    input  logic [NCH-1:0] fb_ov,
    input  logic [NCH-1:0] fb_uv,
    input  logic [NCH-1:0] out_abs_ov,
    input  logic           sup_lockout,
    input  logic           over_temp,
    output logic [NCH-1:0] hs_permit,
    output logic [NCH-1:0] ls_permit,
    output logic [NCH-1:0] dis_on
);
    logic           glob_off;
    logic [NCH-1:0] trip;
    logic [NCH-1:0] uv_fire;
    logic [NCH-1:0] peer_trip;

    assign glob_off = sup_lockout || over_temp;

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            drv_mode_e mode;
            drv_t      drv;

            assign peer_trip[c] = |(trip & ~(NCH'(1) << c));

            vfs_uv_filter #(.UV_FILT(UV_FILT), .UV_BLANK(UV_BLANK)) u_filt (
                .clk  (clk),
                .rst  (rst),
                .en   (ch_en[c]),
                .uv   (fb_uv[c]),
                .fire (uv_fire[c])
            );

            vfs_ch_latch u_lat (
                .clk       (clk),
                .rst       (rst),
                .en        (ch_en[c]),
                .ov        (fb_ov[c]),
                .uv_fire   (uv_fire[c]),
                .abs_ov    (out_abs_ov[c]),
                .peer_trip (peer_trip[c]),
                .glob_off  (glob_off),
                .mode      (mode),
                .trip      (trip[c])
            );

            assign drv          = mode_drive(mode);
            assign hs_permit[c] = drv.hs;
            assign ls_permit[c] = drv.ls;
            assign dis_on[c]    = drv.dis;

            p_disabled_off_r1: assert property (@(posedge clk) disable iff (rst)
                !ch_en[c] |-> (!hs_permit[c] && !ls_permit[c] && dis_on[c]));

            p_ov_clamp_r10: assert property (@(posedge clk) disable iff (rst)
                (ch_en[c] && fb_ov[c]) ##1 ch_en[c] |->
                    (!hs_permit[c] && ls_permit[c] && !dis_on[c]));

            p_dis_no_drive_r11: assert property (@(posedge clk) disable iff (rst)
                dis_on[c] |-> (!hs_permit[c] && !ls_permit[c]));

            p_peer_shut_r7: assert property (@(posedge clk) disable iff (rst)
                (peer_trip[c] && ch_en[c]) ##1 ch_en[c] |-> !hs_permit[c]);
        end
    endgenerate

endmodule

// File: tb/vfs_top_bench.sv
module vfs_top_bench;
    localparam int CLK_P = 10;
    localparam int NCH   = 2;
    localparam int FILT  = 6;
    localparam int BLANK = 20;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [NCH-1:0] ch_en = '0;
    logic [NCH-1:0] fb_ov = '0;
    logic [NCH-1:0] fb_uv = '0;
    logic [NCH-1:0] out_abs_ov = '0;
    logic           sup_lockout = 1'b0;
    logic           over_temp = 1'b0;
    logic [NCH-1:0] hs_permit, ls_permit, dis_on;

    int total = 0;
    int bad   = 0;

    always #(CLK_P/2) clk = ~clk;

    vfs_top #(.NCH(NCH), .UV_FILT(FILT), .UV_BLANK(BLANK)) u_vfs_top (
        .clk(clk), .rst(rst), .ch_en(ch_en), .fb_ov(fb_ov), .fb_uv(fb_uv),
        .out_abs_ov(out_abs_ov), .sup_lockout(sup_lockout), .over_temp(over_temp),
        .hs_permit(hs_permit), .ls_permit(ls_permit), .dis_on(dis_on)
    );

    task automatic step(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    // expected code: 0 run (1,1,0), 1 clamp (0,1,0), 2 off (0,0,1)
    task automatic chk(int ch, int code, string req);
        logic [2:0] exp, got;
        case (code)
            0:       exp = 3'b110;
            1:       exp = 3'b010;
            default: exp = 3'b001;
        endcase
        #1;
        got = {hs_permit[ch], ls_permit[ch], dis_on[ch]};
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s ch%0d: hs/ls/dis got %b expected %b", req, ch, got, exp);
        end
    endtask

    task automatic reenable();
        ch_en = '0;
        step();
        ch_en = '1;
        step(BLANK + 1);
    endtask

    initial begin
        #(CLK_P * 20000);
        bad++;
        total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        step(3);
        rst = 1'b0;
        step();
        chk(0, 2, "R1 reset");
        chk(1, 2, "R1 reset");
        // R1 sweep over enable patterns
        for (int e = 0; e < 4; e++) begin
            ch_en = 2'(e);
            step();
            for (int c = 0; c < NCH; c++) chk(c, ch_en[c] ? 0 : 2, "R1 enable sweep");
        end
        ch_en = '0;
        step();
        ch_en = '1;
        // R5: under-voltage inside blanking window is ignored
        fb_uv[0] = 1'b1;
        step(FILT + 3);
        chk(0, 0, "R5 blanked uv");
        fb_uv[0] = 1'b0;
        step(BLANK);
        chk(0, 0, "R5 after blank");
        // R4: short runs do not latch and restart
        for (int k = 0; k < 3; k++) begin
            fb_uv[0] = 1'b1;
            step(FILT - 1);
            fb_uv[0] = 1'b0;
            step();
            chk(0, 0, "R4 short uv run");
        end
        // R3 and R7
        for (int c = 0; c < NCH; c++) begin
            fb_uv[c] = 1'b1;
            step(FILT - 1);
            chk(c, 0, "R3 before filter end");
            step();
            chk(c, 2, "R3 uv latched");
            chk(1 - c, 0, "R7 peer not yet");
            step();
            chk(1 - c, 2, "R7 peer shut");
            fb_uv[c] = 1'b0;
            step(2);
            chk(c, 2, "R3 uv holds");
            // peer shutdown holds though the tripped channel is disabled
            ch_en[c] = 1'b0;
            step(2);
            chk(1 - c, 2, "R7 peer holds");
            ch_en[1 - c] = 1'b0;
            step();
            ch_en = '1;
            #1;
            chk(c, 0, "R9 cleared");
            chk(1 - c, 0, "R9 cleared peer");
            step(BLANK + 1);
        end
        // R2, R10, R8 with over-voltage latch
        for (int c = 0; c < NCH; c++) begin
            fb_ov[c] = 1'b1;
            step();
            chk(c, 1, "R2 ov clamp");
            chk(1 - c, 0, "R2 no propagation");
            fb_ov[c] = 1'b0;
            step(3);
            chk(c, 1, "R2 ov holds");
            sup_lockout = 1'b1;
            chk(c, 1, "R10 ov over lockout");
            chk(1 - c, 2, "R8 lockout off");
            sup_lockout = 1'b0;
            over_temp = 1'b1;
            chk(c, 1, "R10 ov over thermal");
            over_temp = 1'b0;
            chk(1 - c, 0, "R8 recover");
            fb_uv[c] = 1'b1;
            step(FILT + 2);
            chk(c, 1, "R10 ov over uv");
            fb_uv[c] = 1'b0;
            reenable();
            chk(c, 0, "R9 ov cleared");
            chk(1 - c, 0, "R9 peer run");
        end
        // R6 absolute over-voltage
        for (int c = 0; c < NCH; c++) begin
            out_abs_ov[c] = 1'b1;
            step();
            chk(c, 1, "R6 abs hs off");
            chk(1 - c, 0, "R7 abs peer not yet");
            step();
            chk(1 - c, 2, "R7 abs peer shut");
            out_abs_ov[c] = 1'b0;
            step();
            chk(c, 1, "R6 abs holds");
            reenable();
            chk(c, 0, "R9 abs cleared");
        end
        // R8 exhaustive lockout / thermal combinations
        for (int g = 0; g < 4; g++) begin
            sup_lockout = g[0];
            over_temp = g[1];
            for (int c = 0; c < NCH; c++) chk(c, (g != 0) ? 2 : 0, "R8 global sweep");
            step();
        end
        sup_lockout = 1'b0;
        over_temp = 1'b0;
        step(2);
        for (int c = 0; c < NCH; c++) chk(c, 0, "R8 no latch");
        // R9 global reset clears latches
        fb_ov[0] = 1'b1;
        step();
        fb_ov[0] = 1'b0;
        rst = 1'b1;
        step();
        rst = 1'b0;
        step();
        chk(0, 0, "R9 reset clears");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule